// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block holds the single reservation of one hart for its load-reserved and store-conditional pair, and decides whether each store-conditional may write. A load-reserved event records its address, rounded down to a parameterised reservation granule, and marks the reservation live. A later store-conditional event rounds its own address down to the same granule and compares the result with the recorded one. The outcome appears one cycle later as a one-cycle pulse with a separate pass bit. The core must suppress the memory write when the pass bit is low.

Two kinds of event destroy the reservation. A trap kill covers any exception, any interrupt taken, and any exception return. An external clear can arrive in any cycle. Every store-conditional also ends the reservation, whether it passes or fails. While no reservation is live, the address output reads all ones. The block does not snoop stores from other masters, does not model coherence and does not perform the write.

Top module: `rsv_monitor`

## Requirements
- R1: After synchronous active-high reset, `resv_valid` is 0, `resv_addr` is all ones and `sc_done` is 0.
- R2: A load-reserved event (`lr_fire`) sets `resv_valid` at the next clock edge. It also loads `resv_addr` with `lr_addr` with its low log2(GRAIN_BYTES) bits forced to zero. With the default of 64 bytes, these are the low 6 bits.
- R3: A store-conditional (`sc_fire`) on a live reservation whose address lies in the same granule gives `sc_done`=1 and `sc_pass`=1 in the cycle after the event. This holds even when the low in-granule bits differ.
- R4: A store-conditional with no live reservation, or with an address in a different granule, gives `sc_done`=1 and `sc_pass`=0 in the cycle after the event.
- R5: After any store-conditional, passing or failing, `resv_valid` is 0 and `resv_addr` is all ones.
- R6: `ext_clear` high for one cycle invalidates a live reservation, so a following store-conditional fails.
- R7: `trap_kill` high for one cycle invalidates a live reservation.
- R8: When `trap_kill` or `ext_clear` coincides with a store-conditional, the store-conditional reports failure. When either coincides with a load-reserved event, no reservation is formed.
- R9: A load-reserved event while a reservation is live replaces the recorded address and keeps the reservation live. A store-conditional to the old granule then fails.
- R10: `resv_addr` reads all ones whenever `resv_valid` is 0.
- R11: `sc_done` is high for exactly one cycle per store-conditional event and is low in all other cycles. `sc_pass` is never high while `sc_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lr_fire | input | 1 | Load-reserved event strobe |
| lr_addr | input | ADDR_W | Load-reserved byte address |
| sc_fire | input | 1 | Store-conditional event strobe |
| sc_addr | input | ADDR_W | Store-conditional byte address |
| trap_kill | input | 1 | Trap, interrupt or exception-return strobe |
| ext_clear | input | 1 | External reservation clear strobe |
| sc_done | output | 1 | One-cycle store-conditional result pulse |
| sc_pass | output | 1 | Store-conditional success, valid with sc_done |
| resv_addr | output | ADDR_W | Granule-aligned reservation address, all ones when idle |
| resv_valid | output | 1 | Reservation live |

## Verification
The hardest cases to reach from the ports are the coincident events. These are a kill or clear arriving in the very cycle of a store-conditional, and a kill arriving together with a load-reserved event. In both cases the priority between two strobes decides the outcome, and it is only visible one edge later. The bench drives these pairs together in a single cycle right after forming a fresh reservation. It then inspects the pass bit and the reservation outputs at the next falling edge. The granule boundary is tested separately with addresses one byte inside and one byte beyond the recorded granule.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef struct packed {
    logic done;
    logic pass;
  } sc_result_t;

  function automatic int unsigned grain_lsb(input int unsigned grain_bytes);
    return (grain_bytes <= 1) ? 0 : $clog2(grain_bytes);
  endfunction

endpackage

// File: rtl/rsv_align.sv
module rsv_align #(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned LSB    = 6
) (
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);

  generate
    if (LSB == 0) begin : g_pass
      assign addr_out = addr_in;
    end else begin : g_mask
      assign addr_out = {addr_in[ADDR_W-1:LSB], {LSB{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/rsv_track.sv
module rsv_track #(
  parameter int unsigned ADDR_W = 40,
  parameter int unsigned LSB    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lr_fire,
  input  logic [ADDR_W-1:0] lr_tag,
  input  logic              sc_fire,
  input  logic              kill,
  output logic              valid_q,
  output logic [ADDR_W-1:0] tag_q,
  output logic [ADDR_W-1:0] view_q
);

  localparam logic [ADDR_W-1:0] IDLE_ADDR = '1;

  logic              valid_d;
  logic [ADDR_W-1:0] tag_d;

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    if (kill || sc_fire) valid_d = 1'b0;
    if (lr_fire && !kill) begin
      valid_d = 1'b1;
      tag_d   = lr_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      view_q  <= IDLE_ADDR;
    end else begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
      view_q  <= valid_d ? tag_d : IDLE_ADDR;
    end
  end

  assert_idle_ones_R10: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> (view_q == IDLE_ADDR));

  assert_kill_drops_R7: assert property (@(posedge clk) disable iff (rst)
    kill |=> !valid_q);

  assert_sc_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (sc_fire && !lr_fire) |=> !valid_q);

  assert_lr_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (lr_fire && !kill) |=> (valid_q && view_q == $past(lr_tag)));

endmodule

// File: rtl/rsv_judge.sv
module rsv_judge
  import rsv_pkg::*;
#(
  parameter int unsigned ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sc_fire,
  input  logic [ADDR_W-1:0] sc_tag,
  input  logic              kill,
  input  logic              valid_q,
  input  logic [ADDR_W-1:0] tag_q,
  output sc_result_t        res_q
);

  sc_result_t res_d;

  always_comb begin
    res_d.done = sc_fire;
    res_d.pass = sc_fire && valid_q && !kill && (sc_tag == tag_q);
  end

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= res_d;
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    sc_fire |=> res_q.done);

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !sc_fire |=> !res_q.done);

  assert_pass_in_done_R11: assert property (@(posedge clk) disable iff (rst)
    res_q.pass |-> res_q.done);

  assert_kill_fails_R8: assert property (@(posedge clk) disable iff (rst)
    (sc_fire && kill) |=> !res_q.pass);

  assert_nores_fails_R4: assert property (@(posedge clk) disable iff (rst)
    (sc_fire && !valid_q) |=> !res_q.pass);

endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
  import rsv_pkg::*;
#(
  parameter int unsigned ADDR_W      = 40,
  parameter int unsigned GRAIN_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lr_fire,
  input  logic [ADDR_W-1:0] lr_addr,
  input  logic              sc_fire,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              trap_kill,
  input  logic              ext_clear,
  output logic              sc_done,
  output logic              sc_pass,
  output logic [ADDR_W-1:0] resv_addr,
  output logic              resv_valid
);

  localparam int unsigned LSB = grain_lsb(GRAIN_BYTES);

  logic [ADDR_W-1:0] lr_tag, sc_tag, tag_q, view_q;
  logic              kill, valid_q;
  sc_result_t        res_q;

  assign kill = trap_kill | ext_clear;

  rsv_align #(.ADDR_W(ADDR_W), .LSB(LSB)) u_align_lr (
    .addr_in(lr_addr), .addr_out(lr_tag));

  rsv_align #(.ADDR_W(ADDR_W), .LSB(LSB)) u_align_sc (
    .addr_in(sc_addr), .addr_out(sc_tag));

  rsv_track #(.ADDR_W(ADDR_W), .LSB(LSB)) u_track (
    .clk(clk), .rst(rst), .lr_fire(lr_fire), .lr_tag(lr_tag),
    .sc_fire(sc_fire), .kill(kill),
    .valid_q(valid_q), .tag_q(tag_q), .view_q(view_q));

  rsv_judge #(.ADDR_W(ADDR_W)) u_judge (
    .clk(clk), .rst(rst), .sc_fire(sc_fire), .sc_tag(sc_tag),
    .kill(kill), .valid_q(valid_q), .tag_q(tag_q), .res_q(res_q));

  assign sc_done    = res_q.done;
  assign sc_pass    = res_q.pass;
  assign resv_addr  = view_q;
  assign resv_valid = valid_q;

  assert_clear_drops_R6: assert property (@(posedge clk) disable iff (rst)
    ext_clear |=> !resv_valid);

  assert_match_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (sc_fire && !kill && resv_valid && sc_tag == resv_addr) |=> sc_pass);

endmodule

// File: tb/sim_rsv_monitor.sv
module sim_rsv_monitor;

  localparam int unsigned AW = 40;
  localparam logic [AW-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lr_fire = 0, sc_fire = 0, trap_kill = 0, ext_clear = 0;
  logic [AW-1:0] lr_addr = '0, sc_addr = '0;
  logic sc_done, sc_pass, resv_valid;
  logic [AW-1:0] resv_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rsv_monitor #(.ADDR_W(AW), .GRAIN_BYTES(64)) u0 (
    .clk(clk), .rst(rst), .lr_fire(lr_fire), .lr_addr(lr_addr),
    .sc_fire(sc_fire), .sc_addr(sc_addr), .trap_kill(trap_kill),
    .ext_clear(ext_clear), .sc_done(sc_done), .sc_pass(sc_pass),
    .resv_addr(resv_addr), .resv_valid(resv_valid));

  function automatic logic [AW-1:0] gran(input logic [AW-1:0] a);
    return a & ~(AW'(63));
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic lr, input logic [AW-1:0] la, input logic sc,
                      input logic [AW-1:0] sa, input logic tk, input logic cl);
    lr_fire = lr; lr_addr = la; sc_fire = sc; sc_addr = sa;
    trap_kill = tk; ext_clear = cl;
    @(negedge clk);
    lr_fire = 0; sc_fire = 0; trap_kill = 0; ext_clear = 0;
  endtask

  task automatic idle();
    step(0, '0, 0, '0, 0, 0);
  endtask

  task automatic t_reset();
    check("R1 valid", resv_valid, 0);
    check("R1 addr", resv_addr, ONES);
    check("R1 done", sc_done, 0);
  endtask

  task automatic t_lr();
    step(1, 40'h12345, 0, '0, 0, 0);
    check("R2 valid", resv_valid, 1);
    check("R2 addr", resv_addr, gran(40'h12345));
    check("R11 quiet", sc_done, 0);
  endtask

  task automatic t_sc_pass();
    step(1, 40'h12345, 0, '0, 0, 0);
    step(0, '0, 1, 40'h1237F, 0, 0);
    check("R3 done", sc_done, 1);
    check("R3 pass", sc_pass, 1);
    check("R5 valid", resv_valid, 0);
    check("R5 addr", resv_addr, ONES);
    idle();
    check("R11 pulse ends", sc_done, 0);
    check("R11 pass low", sc_pass, 0);
  endtask

  task automatic t_sc_fail();
    step(0, '0, 1, 40'h12340, 0, 0);
    check("R4 nores done", sc_done, 1);
    check("R4 nores pass", sc_pass, 0);
    step(1, 40'h1000, 0, '0, 0, 0);
    step(0, '0, 1, 40'h1040, 0, 0);
    check("R4 miss done", sc_done, 1);
    check("R4 miss pass", sc_pass, 0);
    check("R5 after fail", resv_valid, 0);
    check("R10 idle addr", resv_addr, ONES);
  endtask

  task automatic t_clear();
    step(1, 40'hABC0, 0, '0, 0, 0);
    step(0, '0, 0, '0, 0, 1);
    check("R6 valid", resv_valid, 0);
    check("R6 addr", resv_addr, ONES);
    step(0, '0, 1, 40'hABC0, 0, 0);
    check("R6 sc after clear", sc_pass, 0);
  endtask

  task automatic t_trap();
    step(1, 40'h7700, 0, '0, 0, 0);
    step(0, '0, 0, '0, 1, 0);
    check("R7 valid", resv_valid, 0);
    step(0, '0, 1, 40'h7700, 0, 0);
    check("R7 sc after trap", sc_pass, 0);
  endtask

  task automatic t_race();
    step(1, 40'h5000, 0, '0, 0, 0);
    step(0, '0, 1, 40'h5000, 1, 0);
    check("R8 sc+trap done", sc_done, 1);
    check("R8 sc+trap pass", sc_pass, 0);
    step(1, 40'h5000, 0, '0, 0, 0);
    step(0, '0, 1, 40'h5008, 0, 1);
    check("R8 sc+clear pass", sc_pass, 0);
    step(1, 40'h6000, 0, '0, 0, 1);
    check("R8 lr+clear valid", resv_valid, 0);
    check("R8 lr+clear addr", resv_addr, ONES);
  endtask

  task automatic t_relr();
    step(1, 40'h8000, 0, '0, 0, 0);
    step(1, 40'h9021, 0, '0, 0, 0);
    check("R9 valid", resv_valid, 1);
    check("R9 addr", resv_addr, gran(40'h9021));
    step(0, '0, 1, 40'h8000, 0, 0);
    check("R9 old granule", sc_pass, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_lr();
    t_sc_pass();
    t_sc_fail();
    t_clear();
    t_trap();
    t_race();
    t_relr();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule